// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block gives a host read access to a serial NOR flash through an address window. Software first loads a 32-bit memory command template that names the read opcode, how many address bytes to send, how many dummy bytes to wait and whether data comes back on one line or several. A valid template switches the engine into memory mode. From then on, every host read request becomes one complete flash read frame, built from the template at the requested byte offset. Each frame returns one 32-bit word.

Each frame drops chip select and sends the opcode serially. It then sends the truncated offset, MSB first, and clocks the dummy cycles with the data line released. Last, it gathers four consecutive flash bytes and returns them little-endian on a valid/ready response. The serial clock idles low, and outgoing data changes only while it is low. Memory mode is left only through a reset request, which aborts any frame in flight and returns the engine to command mode.

Top module: `mmap_flash_rd`

## Requirements
- R1: After rst_ni is released, mcinit_o is 0, cs_no is 1, sck_o is 0, req_ready_o is 0 and rsp_valid_o is 0.
- R2: A template write is accepted only under all of these conditions: bits 23:21 (frame format) hold 2 to 5, meaning opcode plus 1 to 4 address bytes; bit 20 is 0, so the field format in bits 20:19 is 0 or 1; bits 15:0 are 0. An accepted write sets mcinit_o in the cycle after the write. Any other write is ignored and mcinit_o stays 0.
- R3: While mcinit_o is 1, template writes are ignored. mcinit_o stays 1, and later frames still use the stored template.
- R4: A reset_req_i pulse clears mcinit_o in the next cycle and ends any frame in progress (cs_no high, no response). It takes priority over a template write in the same cycle.
- R5: A frame sends the opcode (template bits 31:24) on io_o[0], MSB first. It then sends the host byte offset truncated to (frame format - 1) bytes, also MSB first on io_o[0].
- R6: Template bits 18:16 give a dummy byte count D. Exactly 8*D serial clocks follow the address, so the total serial clock count of a frame is 8 + 8*(address bytes) + 8*D + data clocks.
- R7: With field format 0, data uses 32 clocks sampled on io_i[1]. With field format 1, data uses 32/WIDE_LANES clocks sampled on io_i[WIDE_LANES-1:0], the most significant bit first, with io_i[WIDE_LANES-1] carrying the highest bit of each group.
- R8: rsp_data_o holds the flash byte at the offset in bits 7:0, offset+1 in bits 15:8, offset+2 in bits 23:16 and offset+3 in bits 31:24.
- R9: req_ready_o is 1 only while mcinit_o is 1, no frame is running and no response is pending. Each accepted request produces exactly one chip-select frame.
- R10: While rsp_valid_o is 1 and rsp_ready_i is 0, the response stays valid and rsp_data_o stays unchanged.
- R11: sck_o is low whenever cs_no is high, and io_o[0] changes only in cycles where sck_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mcmd_we_i | input | 1 | Memory command template write strobe |
| mcmd_wdata_i | input | 32 | Memory command template word |
| reset_req_i | input | 1 | Reset request, leaves memory mode |
| req_valid_i | input | 1 | Host read request valid |
| req_addr_i | input | WIN_AW | Byte offset within the window |
| req_ready_o | output | 1 | Request accepted when high with valid |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_ready_i | input | 1 | Host takes read data |
| rsp_data_o | output | 32 | Read data word, little-endian |
| mcinit_o | output | 1 | Memory mode active |
| sck_o | output | 1 | Serial flash clock |
| cs_no | output | 1 | Flash chip select, active low |
| io_i | input | 4 | Flash data lines in |
| io_o | output | 4 | Flash data lines out |
| io_oe_o | output | 4 | Flash data line output enables |

## Verification
The hardest case to reach is a reset request that lands in the middle of a frame. It must end the frame and leave no stray response. The bench reaches it by starting a read and letting the frame run into its opcode clocks, then pulsing the reset request. It then watches that no response ever appears and that requests stay refused. The bench's flash model gets its address only from the pins. Any error in truncation, byte order or lane order therefore shows up as wrong data, not as a masked match. Ignored template writes are checked by the opcode that the next frame actually sends.

// File: rtl/mmap_flash_rd_pkg.sv
package mmap_flash_rd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_DONE
  } phase_e;

  // upper half of the template word
  typedef struct packed {
    logic [7:0] opcode;
    logic [2:0] frame_fmt;
    logic [1:0] field_fmt;
    logic [2:0] dummy_bytes;
  } tmpl_t;

  localparam logic [2:0] FF_MIN = 3'd2;
  localparam logic [2:0] FF_MAX = 3'd5;

  function automatic logic tmpl_ok(logic [31:0] w);
    return (w[23:21] >= FF_MIN) && (w[23:21] <= FF_MAX) &&
           !w[20] && (w[15:0] == 16'h0000);
  endfunction

endpackage

// File: rtl/mfr_tmpl_reg.sv
module mfr_tmpl_reg
  import mmap_flash_rd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        reset_req_i,
  output tmpl_t       tmpl_o,
  output logic        mcinit_o
);

  tmpl_t tmpl_q;
  logic  mcinit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmpl_q   <= '0;
      mcinit_q <= 1'b0;
    end else if (reset_req_i) begin
      tmpl_q   <= '0;
      mcinit_q <= 1'b0;
    end else if (we_i && !mcinit_q && tmpl_ok(wdata_i)) begin
      tmpl_q   <= tmpl_t'(wdata_i[31:16]);
      mcinit_q <= 1'b1;
    end
  end

  assign tmpl_o   = tmpl_q;
  assign mcinit_o = mcinit_q;

endmodule

// File: rtl/mfr_frame_seq.sv
module mfr_frame_seq
  import mmap_flash_rd_pkg::*;
#(
  parameter int unsigned WIDE_LANES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [2:0] nab_i,
  input  logic [2:0] dummy_i,
  input  logic       wide_i,
  output phase_e     phase_o,
  output logic       slot_end_o,
  output logic       sck_o,
  output logic       cs_no,
  output logic       done_o
);

  localparam int unsigned CNT_W     = $clog2(64);
  localparam int unsigned WIDE_CLKS = 32 / WIDE_LANES;

  phase_e           ph_q, ph_nxt;
  logic [CNT_W-1:0] cnt_q, len_nxt;
  logic             half_q;

  always_comb begin
    ph_nxt  = PH_DONE;
    len_nxt = CNT_W'(1);
    unique case (ph_q)
      PH_CMD: begin
        ph_nxt  = PH_ADDR;
        len_nxt = {nab_i, 3'b000};
      end
      PH_ADDR: begin
        if (dummy_i != 3'd0) begin
          ph_nxt  = PH_DUMMY;
          len_nxt = {dummy_i, 3'b000};
        end else begin
          ph_nxt  = PH_DATA;
          len_nxt = wide_i ? CNT_W'(WIDE_CLKS) : CNT_W'(32);
        end
      end
      PH_DUMMY: begin
        ph_nxt  = PH_DATA;
        len_nxt = wide_i ? CNT_W'(WIDE_CLKS) : CNT_W'(32);
      end
      default: begin
        ph_nxt  = PH_DONE;
        len_nxt = CNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (abort_i) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q   <= PH_CMD;
            cnt_q  <= CNT_W'(7);
            half_q <= 1'b0;
          end
        end
        PH_DONE: ph_q <= PH_IDLE;
        default: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (cnt_q == '0) begin
              ph_q  <= ph_nxt;
              cnt_q <= len_nxt - CNT_W'(1);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign phase_o    = ph_q;
  assign slot_end_o = half_q;
  assign sck_o      = half_q;
  assign cs_no      = (ph_q == PH_IDLE) || (ph_q == PH_DONE);
  assign done_o     = (ph_q == PH_DONE);

endmodule

// File: rtl/mfr_shift_path.sv
module mfr_shift_path
  import mmap_flash_rd_pkg::*;
#(
  parameter int unsigned WIN_AW     = 24,
  parameter int unsigned WIDE_LANES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        opcode_i,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [2:0]        nab_i,
  input  logic              wide_i,
  input  phase_e            phase_i,
  input  logic              slot_end_i,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic [31:0]       rx_o
);

  localparam int unsigned TX_W = 40;

  logic [TX_W-1:0] tx_q;
  logic [31:0]     rx_q, rx_ser, rx_wide;
  logic [31:0]     addr32, addr_al;
  logic            drive;

  assign addr32  = 32'(addr_i);
  assign addr_al = addr32 << {(3'd4 - nab_i), 3'b000};
  assign drive   = (phase_i == PH_CMD) || (phase_i == PH_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= {opcode_i, addr_al};
    end else if (slot_end_i && drive) begin
      tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end
  end

  assign rx_ser  = {rx_q[30:0], io_i[1]};
  assign rx_wide = {rx_q[31-WIDE_LANES:0], io_i[WIDE_LANES-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (slot_end_i && (phase_i == PH_DATA)) begin
      rx_q <= wide_i ? rx_wide : rx_ser;
    end
  end

  assign io_o[0]    = tx_q[TX_W-1];
  assign io_oe_o[0] = drive;

  // upper lanes are inputs only in this engine
  for (genvar l = 1; l < 4; l++) begin : g_lane_in
    assign io_o[l]    = 1'b0;
    assign io_oe_o[l] = 1'b0;
  end

  assign rx_o = rx_q;

endmodule

// File: rtl/mmap_flash_rd.sv
module mmap_flash_rd
  import mmap_flash_rd_pkg::*;
#(
  parameter int unsigned WIN_AW     = 24,
  parameter int unsigned WIDE_LANES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mcmd_we_i,
  input  logic [31:0]       mcmd_wdata_i,
  input  logic              reset_req_i,
  input  logic              req_valid_i,
  input  logic [WIN_AW-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_data_o,
  output logic              mcinit_o,
  output logic              sck_o,
  output logic              cs_no,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o
);

  localparam int unsigned NBYTES = 4;

  tmpl_t       tmpl;
  logic        mcinit;
  phase_e      phase;
  logic        slot_end, done, start, wide;
  logic [2:0]  nab;
  logic [31:0] rx, rx_le, data_q;
  logic        rsp_q;

  mfr_tmpl_reg u_tmpl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (mcmd_we_i),
    .wdata_i     (mcmd_wdata_i),
    .reset_req_i (reset_req_i),
    .tmpl_o      (tmpl),
    .mcinit_o    (mcinit)
  );

  assign nab  = tmpl.frame_fmt - 3'd1;
  assign wide = tmpl.field_fmt[0];

  assign req_ready_o = mcinit && (phase == PH_IDLE) && !rsp_q;
  assign start       = req_valid_i && req_ready_o && !reset_req_i;

  mfr_frame_seq #(.WIDE_LANES(WIDE_LANES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (reset_req_i),
    .nab_i      (nab),
    .dummy_i    (tmpl.dummy_bytes),
    .wide_i     (wide),
    .phase_o    (phase),
    .slot_end_o (slot_end),
    .sck_o      (sck_o),
    .cs_no      (cs_no),
    .done_o     (done)
  );

  mfr_shift_path #(.WIN_AW(WIN_AW), .WIDE_LANES(WIDE_LANES)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .opcode_i   (tmpl.opcode),
    .addr_i     (req_addr_i),
    .nab_i      (nab),
    .wide_i     (wide),
    .phase_i    (phase),
    .slot_end_i (slot_end),
    .io_i       (io_i),
    .io_o       (io_o),
    .io_oe_o    (io_oe_o),
    .rx_o       (rx)
  );

  // first received byte is the lowest address
  for (genvar b = 0; b < NBYTES; b++) begin : g_le
    assign rx_le[8*b +: 8] = rx[8*(NBYTES-1-b) +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= 1'b0;
      data_q <= '0;
    end else if (reset_req_i) begin
      rsp_q  <= 1'b0;
    end else if (done) begin
      rsp_q  <= 1'b1;
      data_q <= rx_le;
    end else if (rsp_q && rsp_ready_i) begin
      rsp_q  <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rsp_data_o  = data_q;
  assign mcinit_o    = mcinit;

endmodule

// File: rtl/mmap_flash_rd_chk.sv
module mmap_flash_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mcmd_we_i,
  input logic        reset_req_i,
  input logic        mcinit_o,
  input logic        cs_no,
  input logic        sck_o,
  input logic [3:0]  io_o,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [31:0] rsp_data_o
);

  p_mcinit_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mcinit_o) |-> $past(mcmd_we_i));

  p_mode_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcinit_o && !reset_req_i |=> mcinit_o);

  p_reset_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> !mcinit_o && cs_no && !rsp_valid_o);

  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mcinit_o && cs_no && !rsp_valid_o);

  p_rsp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i && !reset_req_i |=> rsp_valid_o && $stable(rsp_data_o));

  p_sck_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  p_tx_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(io_o[0]) |-> !sck_o);

endmodule

bind mmap_flash_rd mmap_flash_rd_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mcmd_we_i   (mcmd_we_i),
  .reset_req_i (reset_req_i),
  .mcinit_o    (mcinit_o),
  .cs_no       (cs_no),
  .sck_o       (sck_o),
  .io_o        (io_o),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/mmap_flash_rd_tb_top.sv
`timescale 1ns/1ps
module mmap_flash_rd_tb_top;

  localparam int unsigned WIN_AW = 24;
  localparam int unsigned LANES  = 4;
  localparam int unsigned NV     = 6;

  localparam logic [31:0] TMPL_V [NV] = '{
    32'h0380_0000, 32'h0B81_0000, 32'h3B89_0000,
    32'h6BA9_0000, 32'h1340_0000, 32'hEB6B_0000
  };
  localparam logic [23:0] ADDR_V [NV] = '{
    24'h012345, 24'hABCDEF, 24'h000100,
    24'hFEDCBA, 24'h0012F7, 24'h7FFFFF
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              mcmd_we = 1'b0;
  logic [31:0]       mcmd_wdata = '0;
  logic              reset_req = 1'b0;
  logic              req_valid = 1'b0;
  logic [WIN_AW-1:0] req_addr = '0;
  logic              req_ready, rsp_valid, rsp_ready, mcinit, sck, cs_n;
  logic [31:0]       rsp_data;
  logic [3:0]        io_in, io_out, io_oe;

  initial rsp_ready = 1'b0;

  mmap_flash_rd #(.WIN_AW(WIN_AW), .WIDE_LANES(LANES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mcmd_we_i(mcmd_we), .mcmd_wdata_i(mcmd_wdata),
    .reset_req_i(reset_req), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .mcinit_o(mcinit), .sck_o(sck), .cs_no(cs_n),
    .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  function automatic logic [7:0] fb(logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd37 + (a >> 8) + 32'h1B;
    return t[7:0];
  endfunction

  // flash model configuration, set from the template the bench writes
  int          m_nab = 3, m_dum = 0;
  bit          m_wide = 0;
  int          rise = 0, last_rise = 0, frames = 0, oe_bad = 0;
  logic [7:0]  op_cap = '0;
  logic [31:0] addr_cap = '0;
  logic        sck_p = 1'b0, cs_p = 1'b1;

  initial io_in = '0;

  always @(negedge clk) begin
    int hdr, s, nslots;
    logic [31:0] st;
    hdr    = 8 + 8 * m_nab + 8 * m_dum;
    nslots = m_wide ? 32 / LANES : 32;
    if (cs_p && !cs_n) begin
      rise = 0; op_cap = '0; addr_cap = '0; io_in = '0;
    end
    if (!cs_n && sck && !sck_p) begin
      rise++;
      if (rise <= 8) op_cap = {op_cap[6:0], io_out[0]};
      else if (rise <= 8 + 8 * m_nab) addr_cap = {addr_cap[30:0], io_out[0]};
      else if (io_oe[0]) oe_bad++;
    end
    if (!cs_n && !sck && sck_p && rise >= hdr) begin
      s  = rise - hdr;
      st = {fb(addr_cap), fb(addr_cap + 1), fb(addr_cap + 2), fb(addr_cap + 3)};
      if (s < nslots) begin
        if (m_wide) io_in = st[31 - s * LANES -: LANES];
        else io_in = {2'b00, st[31 - s], 1'b0};
      end
    end
    if (!cs_p && cs_n) begin
      last_rise = rise; frames++;
    end
    sck_p = sck; cs_p = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_tmpl(input logic [31:0] w);
    @(negedge clk); mcmd_we = 1'b1; mcmd_wdata = w;
    @(negedge clk); mcmd_we = 1'b0;
  endtask

  task automatic pulse_reset;
    @(negedge clk); reset_req = 1'b1;
    @(negedge clk); reset_req = 1'b0;
  endtask

  task automatic set_model(input logic [31:0] w);
    m_nab  = int'(w[23:21]) - 1;
    m_dum  = int'(w[18:16]);
    m_wide = w[19];
  endtask

  task automatic issue(input logic [WIN_AW-1:0] a);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [WIN_AW-1:0] a, output logic [31:0] d);
    issue(a);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp_d, ma, d2;
    int f0, nab;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mcinit && cs_n && !sck && !req_ready && !rsp_valid, "R1 reset state",
        {27'b0, mcinit, cs_n, sck, req_ready, rsp_valid}, 32'h0000_0008);

    // R2 rejected templates
    write_tmpl(32'h9F20_0000);
    chk(!mcinit, "R2 frame format 1 rejected", {31'b0, mcinit}, 32'h0);
    write_tmpl(32'h03C0_0000);
    chk(!mcinit, "R2 frame format 6 rejected", {31'b0, mcinit}, 32'h0);
    write_tmpl(32'h0390_0000);
    chk(!mcinit, "R2 field format 2 rejected", {31'b0, mcinit}, 32'h0);
    write_tmpl(32'h0380_0004);
    chk(!mcinit, "R2 nonzero low bits rejected", {31'b0, mcinit}, 32'h0);
    repeat (3) @(negedge clk);
    chk(!req_ready, "R9 no ready outside memory mode", {31'b0, req_ready}, 32'h0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      pulse_reset();
      set_model(TMPL_V[i]);
      write_tmpl(TMPL_V[i]);
      chk(mcinit, $sformatf("R2 mcinit set v%0d", i), {31'b0, mcinit}, 32'h1);
      nab = int'(TMPL_V[i][23:21]) - 1;
      ma  = (nab == 4) ? 32'(ADDR_V[i]) : (32'(ADDR_V[i]) & ((32'h1 << (8 * nab)) - 1));
      f0  = frames;
      do_read(ADDR_V[i], d);
      exp_d = {fb(ma + 3), fb(ma + 2), fb(ma + 1), fb(ma)};
      chk(op_cap == TMPL_V[i][31:24], $sformatf("R5 opcode v%0d", i), 32'(op_cap), 32'(TMPL_V[i][31:24]));
      chk(addr_cap == ma, $sformatf("R5 address v%0d", i), addr_cap, ma);
      chk(last_rise == 8 + 8 * nab + 8 * int'(TMPL_V[i][18:16]) + (TMPL_V[i][19] ? 32 / LANES : 32),
          $sformatf("R6 clock count v%0d", i), 32'(last_rise),
          32'(8 + 8 * nab + 8 * int'(TMPL_V[i][18:16]) + (TMPL_V[i][19] ? 32 / LANES : 32)));
      chk(d == exp_d, $sformatf("R7 R8 data v%0d", i), d, exp_d);
      chk(frames == f0 + 1, $sformatf("R9 one frame v%0d", i), 32'(frames), 32'(f0 + 1));
    end
    chk(oe_bad == 0, "R6 data line released during dummy", 32'(oe_bad), 32'h0);

    // R3 write ignored in memory mode
    pulse_reset();
    set_model(TMPL_V[0]);
    write_tmpl(TMPL_V[0]);
    write_tmpl(32'h0B80_0000);
    chk(mcinit, "R3 mcinit stays set", {31'b0, mcinit}, 32'h1);
    do_read(24'h000040, d);
    chk(op_cap == 8'h03, "R3 old opcode still used", 32'(op_cap), 32'h03);
    chk(d == {fb(32'h43), fb(32'h42), fb(32'h41), fb(32'h40)}, "R3 R8 data after ignored write",
        d, {fb(32'h43), fb(32'h42), fb(32'h41), fb(32'h40)});

    // R10 backpressure
    issue(24'h000200);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    repeat (4) @(negedge clk);
    d2 = rsp_data;
    chk(rsp_valid && d2 == d, "R10 response held", d2, d);
    chk(!req_ready, "R9 no ready with pending response", {31'b0, req_ready}, 32'h0);
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 R10 ready after consume", {30'b0, rsp_valid, req_ready}, 32'h1);

    // R4 abort mid-frame
    issue(24'h000300);
    repeat (6) @(negedge clk);
    chk(!cs_n, "R4 frame running before abort", {31'b0, cs_n}, 32'h0);
    pulse_reset();
    chk(cs_n && !mcinit, "R4 abort ends frame and mode", {30'b0, cs_n, mcinit}, 32'h2);
    repeat (120) @(negedge clk);
    chk(!rsp_valid && !req_ready, "R4 no response after abort", {30'b0, rsp_valid, req_ready}, 32'h0);

    // R4 reset wins over same-cycle write
    @(negedge clk); mcmd_we = 1'b1; mcmd_wdata = TMPL_V[1]; reset_req = 1'b1;
    @(negedge clk); mcmd_we = 1'b0; reset_req = 1'b0;
    chk(!mcinit, "R4 reset beats write", {31'b0, mcinit}, 32'h0);

    // R11 idle clock
    chk(!sck && cs_n, "R11 clock low while deselected", {30'b0, sck, cs_n}, 32'h1);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule